// File: doc/BRIEF.md
# Table-Driven Crossing Light Controller

This block runs the signals at a crossing of two one-way roads, one carrying northbound traffic and one carrying eastbound traffic. Each road has a red, a yellow and a green lamp, and the controller drives all six through one registered lamp word. The controller moves through four phases: north green, north yellow, east green and east yellow. Each phase keeps its lamp pattern for a fixed dwell that is counted in 10 ms ticks.

When a dwell runs out, the controller reads two car-presence sensors once. It then looks up the next phase in a constant table that holds four successor entries per phase, and the 2-bit sensor word selects the entry. The lamp patterns, the dwell lengths and the successors are all stored as data in that table. A new phase graph therefore needs only a table edit and no change to the control logic. Both sensor inputs pass through a flop synchronizer before use. A free-running prescaler produces a one-cycle tick every `CYCLES_PER_TICK` clocks.

Top module: `xing_light_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in north-green with lamp word 0x21. Reset also restarts the full north-green dwell, so the first move comes `GO_TICKS` ticks after reset is released.
- R2: The lamp word has this layout: bit5 east red, bit4 east yellow, bit3 east green, bit2 north red, bit1 north yellow, bit0 north green. The patterns are north-green 0x21, north-yellow 0x22, east-green 0x0C and east-yellow 0x14.
- R3: A tick occurs once every `CYCLES_PER_TICK` clocks. A green phase lasts `GO_TICKS` ticks (default 30) and a yellow phase lasts `WAIT_TICKS` ticks (default 5). A phase entered at clock c therefore changes at clock c + dwell × `CYCLES_PER_TICK`.
- R4: The sensor word is north × 2 + east, so bit1 means northbound cars are waiting and bit0 means eastbound cars are waiting. From north-green the controller moves to north-yellow when bit0 is set, and otherwise it stays in north-green.
- R5: From east-green the controller moves to east-yellow when bit1 is set, and otherwise it stays in east-green. With no sensor active, either green phase holds indefinitely.
- R6: North-yellow always moves to east-green, and east-yellow always moves to north-green, whatever the sensor word.
- R7: The sensors pass through a two-flop synchronizer and are read only on the tick that ends a dwell. Sensor changes that are gone before the end of the dwell have no effect.
- R8: With both sensors held active, the controller cycles north-green, north-yellow, east-green, east-yellow and back again without stopping.
- R9: Exactly one lamp per road is lit in every cycle. A lit green lamp is always followed by that road's yellow lamp and never directly by red.
- R10: The lamp word is registered and changes only in the cycle in which the phase register updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| north_car | input | 1 | Northbound car presence, asynchronous |
| east_car | input | 1 | Eastbound car presence, asynchronous |
| lamps | output | 6 | Registered lamp word (layout in R2) |

## Verification
The bench builds the controller with `CYCLES_PER_TICK` = 4 and keeps the default dwell lengths of 30 and 5 ticks. With these values a green phase lasts 120 clocks and a yellow phase lasts 20 clocks, so the real dwell counts are checked to the exact clock. Each phase still leaves room to toggle a sensor well inside the dwell, and to assert reset partway through a phase, before the deciding tick arrives.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  localparam int LAMP_W   = 6;
  localparam int SENSE_W  = 2;
  localparam int N_PHASES = 4;

  // Lamp bit positions. A neighbour decodes these, so they stay fixed.
  localparam int LB_N_GRN = 0;
  localparam int LB_N_YEL = 1;
  localparam int LB_N_RED = 2;
  localparam int LB_E_GRN = 3;
  localparam int LB_E_YEL = 4;
  localparam int LB_E_RED = 5;

  typedef enum logic [1:0] {
    PH_GO_N   = 2'd0,
    PH_HOLD_N = 2'd1,
    PH_GO_E   = 2'd2,
    PH_HOLD_E = 2'd3
  } phase_t;

  // One table row: lamp pattern, dwell class, successor per sensor word.
  typedef struct packed {
    logic [LAMP_W-1:0]         lamps;
    logic                      long_dwell;
    phase_t [N_PHASES-1:0]     succ;
  } row_t;

  function automatic logic [LAMP_W-1:0] lamp_word(phase_t p);
    logic [LAMP_W-1:0] w;
    w = '0;
    case (p)
      PH_GO_N:   begin w[LB_N_GRN] = 1'b1; w[LB_E_RED] = 1'b1; end
      PH_HOLD_N: begin w[LB_N_YEL] = 1'b1; w[LB_E_RED] = 1'b1; end
      PH_GO_E:   begin w[LB_E_GRN] = 1'b1; w[LB_N_RED] = 1'b1; end
      default:   begin w[LB_E_YEL] = 1'b1; w[LB_N_RED] = 1'b1; end
    endcase
    return w;
  endfunction

  // Phase graph as data: sensor word = {north, east}.
  function automatic row_t phase_row(phase_t p);
    row_t r;
    r = '0;
    r.lamps = lamp_word(p);
    case (p)
      PH_GO_N: begin
        r.long_dwell = 1'b1;
        r.succ[0] = PH_GO_N;
        r.succ[1] = PH_HOLD_N;
        r.succ[2] = PH_GO_N;
        r.succ[3] = PH_HOLD_N;
      end
      PH_HOLD_N: begin
        r.long_dwell = 1'b0;
        r.succ[0] = PH_GO_E;
        r.succ[1] = PH_GO_E;
        r.succ[2] = PH_GO_E;
        r.succ[3] = PH_GO_E;
      end
      PH_GO_E: begin
        r.long_dwell = 1'b1;
        r.succ[0] = PH_GO_E;
        r.succ[1] = PH_GO_E;
        r.succ[2] = PH_HOLD_E;
        r.succ[3] = PH_HOLD_E;
      end
      default: begin
        r.long_dwell = 1'b0;
        r.succ[0] = PH_GO_N;
        r.succ[1] = PH_GO_N;
        r.succ[2] = PH_GO_N;
        r.succ[3] = PH_GO_N;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tlc_tick_gen.sv
module tlc_tick_gen #(
  parameter int CYCLES_PER_TICK = 2_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CYCLES_PER_TICK > 2) ? $clog2(CYCLES_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_TICK - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // Ticks are isolated single-cycle pulses (R3).
  p_tick_isolated_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/tlc_sync.sv
module tlc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/tlc_phase_rom.sv
module tlc_phase_rom
  import tlc_pkg::*;
(
  input  phase_t              cur,
  input  logic [SENSE_W-1:0]  sensors,
  output phase_t              succ,
  output logic [LAMP_W-1:0]   succ_lamps,
  output logic                succ_long
);
  row_t rows [N_PHASES];

  for (genvar g = 0; g < N_PHASES; g++) begin : g_row
    assign rows[g] = phase_row(phase_t'(g));
  end

  always_comb begin
    succ       = rows[cur].succ[sensors];
    succ_lamps = rows[succ].lamps;
    succ_long  = rows[succ].long_dwell;
  end

endmodule

// File: rtl/tlc_dwell_timer.sv
module tlc_dwell_timer #(
  parameter int GO_TICKS   = 30,
  parameter int WAIT_TICKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic next_long,
  output logic done
);
  localparam int MAXT = (GO_TICKS > WAIT_TICKS) ? GO_TICKS : WAIT_TICKS;
  localparam int RW   = $clog2(MAXT + 1);
  localparam logic [RW-1:0] GO_LD   = RW'(GO_TICKS);
  localparam logic [RW-1:0] WAIT_LD = RW'(WAIT_TICKS);
  localparam logic [RW-1:0] ONE     = RW'(1);

  logic [RW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst)        rem <= GO_LD;
    else if (done)  rem <= next_long ? GO_LD : WAIT_LD;
    else if (tick)  rem <= rem - ONE;
  end

  assign done = tick && (rem == ONE);

  // Remaining count never reaches zero (R3).
  p_rem_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    rem != '0);

  // A mid-dwell tick consumes exactly one unit (R3).
  p_countdown_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !done) |=> (rem == $past(rem) - ONE));

  // Without a tick the count holds (R7: nothing else moves it).
  p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(rem));

endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl
  import tlc_pkg::*;
#(
  parameter int CYCLES_PER_TICK = 2_000_000,
  parameter int GO_TICKS        = 30,
  parameter int WAIT_TICKS      = 5,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              north_car,
  input  logic              east_car,
  output logic [LAMP_W-1:0] lamps
);
  localparam logic [LAMP_W-1:0] RESET_LAMPS = lamp_word(PH_GO_N);

  logic [SENSE_W-1:0] sens_s;
  logic               tick;
  logic               done;
  phase_t             phase_q;
  phase_t             succ;
  logic [LAMP_W-1:0]  succ_lamps;
  logic               succ_long;

  tlc_sync #(.WIDTH(SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({north_car, east_car}),
    .q   (sens_s)
  );

  tlc_tick_gen #(.CYCLES_PER_TICK(CYCLES_PER_TICK)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  tlc_phase_rom u_rom (
    .cur        (phase_q),
    .sensors    (sens_s),
    .succ       (succ),
    .succ_lamps (succ_lamps),
    .succ_long  (succ_long)
  );

  tlc_dwell_timer #(.GO_TICKS(GO_TICKS), .WAIT_TICKS(WAIT_TICKS)) u_dwell (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .next_long (succ_long),
    .done      (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_GO_N;
      lamps   <= RESET_LAMPS;
    end else if (done) begin
      phase_q <= succ;
      lamps   <= succ_lamps;
    end
  end

  // One lamp per road at all times (R9).
  p_one_lamp_per_road_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(lamps[LB_N_RED:LB_N_GRN]) == 1) &&
    ($countones(lamps[LB_E_RED:LB_E_GRN]) == 1));

  // Green always gives way to yellow (R9).
  p_north_green_to_yellow_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(lamps[LB_N_GRN]) |-> lamps[LB_N_YEL]);
  p_east_green_to_yellow_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(lamps[LB_E_GRN]) |-> lamps[LB_E_YEL]);

  // Lamps move only with the phase register (R10).
  p_lamps_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(lamps) && $stable(phase_q)));

  // Yellow phases leave unconditionally to the other green (R6).
  p_hold_n_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (done && phase_q == PH_HOLD_N) |=> (phase_q == PH_GO_E));
  p_hold_e_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (done && phase_q == PH_HOLD_E) |=> (phase_q == PH_GO_N));

  // Idle sensors keep a green phase (R5).
  p_idle_keeps_green_r5: assert property (@(posedge clk) disable iff (rst)
    (done && sens_s == '0 && (phase_q == PH_GO_N || phase_q == PH_GO_E))
      |=> $stable(phase_q));

endmodule

// File: tb/tb_xing_light_ctrl.sv
`timescale 1ns/1ps
module tb_xing_light_ctrl;
  localparam int CPT    = 4;
  localparam int GO_T   = 30;
  localparam int WAIT_T = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       north_car = 1'b0;
  logic       east_car  = 1'b0;
  logic [5:0] lamps;

  int cyc;
  int checks   = 0;
  int failures = 0;
  int onehot_bad = 0;

  logic [5:0] exp_lamp_q [$];
  int         exp_cyc_q  [$];
  int         model_ph;
  int         t_start;
  logic [5:0] prev_lamps;

  always #2.5 clk = ~clk;

  xing_light_ctrl #(
    .CYCLES_PER_TICK (CPT),
    .GO_TICKS        (GO_T),
    .WAIT_TICKS      (WAIT_T),
    .SYNC_STAGES     (2)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .north_car (north_car),
    .east_car  (east_car),
    .lamps     (lamps)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Independent model of the requirements.
  function automatic logic [5:0] m_lamp(int p);
    case (p)
      0: return 6'h21;
      1: return 6'h22;
      2: return 6'h0C;
      default: return 6'h14;
    endcase
  endfunction

  function automatic bit m_long(int p);
    return (p == 0) || (p == 2);
  endfunction

  function automatic int m_next(int p, logic [1:0] s);
    case (p)
      0: return s[0] ? 1 : 0;
      1: return 2;
      2: return s[1] ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: pops expected transitions as the lamps change.
  always @(negedge clk) begin
    if (rst) begin
      prev_lamps = lamps;
    end else begin
      if ($countones(lamps[2:0]) != 1 || $countones(lamps[5:3]) != 1)
        onehot_bad++;
      if (lamps !== prev_lamps) begin
        if (exp_lamp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected lamp change", int'(lamps), int'(prev_lamps));
        end else begin
          logic [5:0] el;
          int         ec;
          el = exp_lamp_q.pop_front();
          ec = exp_cyc_q.pop_front();
          check(lamps == el, "R2", "lamp pattern on change", int'(lamps), int'(el));
          check(cyc == ec, "R3", "cycle of change", cyc, ec);
          if ((prev_lamps[0] && !lamps[0]) || (prev_lamps[3] && !lamps[3]))
            check(lamps[1] || lamps[4], "R9", "green left without yellow",
                  int'(lamps), int'(el));
        end
        prev_lamps = lamps;
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    north_car = 1'b0;
    east_car  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_lamp_q.delete();
    exp_cyc_q.delete();
    model_ph = 0;
    t_start  = 0;
    check(lamps == 6'h21, "R1", "lamps after reset", int'(lamps), 'h21);
  endtask

  // Driver: one full phase with sensor word s, optional mid-dwell glitch.
  task automatic step(logic [1:0] s, bit glitch, string req);
    int d;
    int t_end;
    int nx;
    d     = (m_long(model_ph) ? GO_T : WAIT_T) * CPT;
    t_end = t_start + d;
    nx    = m_next(model_ph, s);
    if (nx != model_ph) begin
      exp_lamp_q.push_back(m_lamp(nx));
      exp_cyc_q.push_back(t_end);
    end
    {north_car, east_car} = s;
    if (glitch) begin
      while (cyc < t_start + 5) @(negedge clk);
      {north_car, east_car} = ~s;
      while (cyc < t_start + d / 2) @(negedge clk);
      {north_car, east_car} = s;
    end
    while (cyc < t_end) @(negedge clk);
    @(negedge clk);
    check(exp_lamp_q.size() == 0, req, "transition still pending",
          exp_lamp_q.size(), 0);
    check(lamps == m_lamp(nx), req, "lamps after dwell", int'(lamps), int'(m_lamp(nx)));
    model_ph = nx;
    t_start  = t_end;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    do_reset();
    step(2'b00, 1'b0, "R5");   // north green, idle: holds
    step(2'b10, 1'b0, "R4");   // own-road sensor: holds
    step(2'b00, 1'b1, "R7");   // glitch to 11 mid-dwell: ignored
    step(2'b01, 1'b0, "R4");   // east waiting: to north yellow
    step(2'b10, 1'b0, "R6");   // yellow ignores sensors: to east green
    step(2'b01, 1'b0, "R5");   // east green, own sensor: holds
    step(2'b00, 1'b0, "R5");   // east green, idle: holds
    step(2'b01, 1'b1, "R7");   // glitch to 10 mid-dwell: ignored
    step(2'b10, 1'b0, "R5");   // north waiting: to east yellow
    step(2'b01, 1'b0, "R6");   // east yellow: to north green
    for (int i = 0; i < 8; i++) step(2'b11, 1'b0, "R8");

    // Reset partway through a dwell with a pending east request.
    north_car = 1'b0;
    east_car  = 1'b1;
    while (cyc < t_start + 40) @(negedge clk);
    do_reset();
    step(2'b01, 1'b0, "R1");   // full 120-cycle dwell after reset
    step(2'b11, 1'b0, "R6");

    check(onehot_bad == 0, "R9", "cycles without one lamp per road", onehot_bad, 0);
    finish_run();
  end

endmodule